// File: doc/BRIEF.md
# Receive IP Header Parser and Checker

This block sits on the receive side of an Ethernet datapath. It watches a byte stream framed by start-of-packet and end-of-packet markers, qualified by a valid strobe, that begins at the first byte of the destination MAC address. From the type field that follows the two MAC addresses it decides whether the frame carries IP. It then reads the IP header byte by byte, checks the version and, for IPv4, the header checksum. It extracts the fields a downstream layer-4 checksum unit needs: source and destination addresses, the upper-layer protocol and the upper-layer length, plus a fragment indication.

Two nested cases are resolved inside the same pass. An IPv4 header whose protocol announces an encapsulated IPv6 packet is followed into that inner header, and the inner values are reported. An IPv6 routing extension header of type 0 is skipped. The protocol it points to becomes the reported upper layer, and its last listed address becomes the reported destination. Nothing is buffered. All results are computed on the fly and presented as a one-cycle status word right after the final byte of the frame.

Top module: `rx_ip_hdr_parser`

## Requirements
- R1: `st_valid` is high for exactly the one cycle after the clock edge that accepts a byte with `in_valid` and `in_eop` both high, and all status outputs are zero after reset.
- R2: Frame bytes 12 and 13 form the type field. Only 0x0800 or 0x86DD set `st_is_ip`. Any other value leaves every other flag, the protocol, the length and both addresses at zero.
- R3: The high nibble of the first IP header byte selects the parse: 4 for IPv4, 6 for IPv6. Any other value sets `st_ver_err`, clears `st_is_v4` and `st_is_v6`, and stops the parse.
- R4: For IPv4, the 16-bit ones'-complement sum of the header words over IHL×4 bytes (IHL is the low nibble of byte 0) must equal 0xFFFF, or `st_csum_err` is set. An IHL below 5 sets `st_csum_err` and stops the parse.
- R5: For IPv4, `st_proto` is header byte 9. `st_src[31:0]` holds bytes 12–15 and `st_dst[31:0]` holds bytes 16–19, first byte most significant, with the upper address bits zero. `st_paylen` is the total length (bytes 2–3) minus IHL×4.
- R6: `st_frag` is set when the more-fragments bit (bit 5 of IPv4 byte 6) is 1 or the 13-bit fragment offset (byte 6 bits 4:0 and byte 7) is nonzero. The don't-fragment bit (bit 6) has no effect.
- R7: For IPv6, `st_paylen` is bytes 4–5, `st_proto` is byte 6, `st_src` is bytes 8–23 and `st_dst` is bytes 24–39. `st_csum_err` is never set by an IPv6 header.
- R8: An IPv4 header with protocol 41 is followed by a second IP header that is parsed in turn. `st_tunnel` is set, and version, protocol, length and addresses come from the inner header. Fragment and checksum results of the outer header are kept.
- R9: An IPv6 next header of 43 starts a routing header: byte 0 is the next header, byte 1 is the length in 8-byte units beyond the first 8, and byte 2 is the type. For type 0, `st_rt0` is set, `st_proto` takes its next header, `st_paylen` is reduced by its length, and, when it is at least 24 bytes, `st_dst` takes its last 16 bytes. For any other type, `st_proto` stays 43 and the other fields are unchanged.
- R10: `st_short` is set when the frame ends before the IP header chain has been fully read.
- R11: A byte with `in_sop` high restarts parsing from scratch, even mid-frame. Cycles with `in_valid` low neither advance the parse nor produce status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| st_valid | output | 1 | Status word valid (one cycle) |
| st_is_ip | output | 1 | Type field announced IP |
| st_is_v4 | output | 1 | Innermost header is IPv4 |
| st_is_v6 | output | 1 | Innermost header is IPv6 |
| st_tunnel | output | 1 | IPv6 carried in IPv4 was followed |
| st_rt0 | output | 1 | Type 0 routing header skipped |
| st_ver_err | output | 1 | Version neither 4 nor 6 |
| st_csum_err | output | 1 | IPv4 header checksum or length error |
| st_frag | output | 1 | Packet is a fragment |
| st_short | output | 1 | Frame ended inside the header chain |
| st_proto | output | 8 | Upper-layer protocol |
| st_paylen | output | 16 | Upper-layer length in bytes |
| st_src | output | 128 | Source address (IPv4 in low 32 bits) |
| st_dst | output | 128 | Destination address (IPv4 in low 32 bits) |

## Verification
The parser is fed whole frames of several kinds: plain IPv4 with and without options, with a correct and a corrupted checksum, and with IHL too small; non-IP frames; frames with a bad version; plain IPv6; IPv6 with a type 0 and a non-zero-type routing header; and IPv6 tunnelled in IPv4. The checksum cases separate a correct sum from a single flipped bit. The option case shows that the header length, not a fixed 20 bytes, bounds the sum and the payload length. The fragment cases tell the more-fragments bit and a bare offset apart from the don't-fragment bit. The routing and tunnel cases show that the reported protocol, length and addresses come from the innermost header, and the truncated, restarted and gapped streams show that framing rather than byte timing drives the parse.

// File: rtl/rx_ip_pkg.sv
package rx_ip_pkg;

  localparam int ADDR_W = 128;

  localparam logic [15:0] ETY_IPV4    = 16'h0800;
  localparam logic [15:0] ETY_IPV6    = 16'h86DD;
  localparam logic [7:0]  PROTO_6IN4  = 8'd41;
  localparam logic [7:0]  NH_ROUTING  = 8'd43;

  typedef enum logic [2:0] {
    W_ETH, W_IP0, W_V4, W_V6, W_RT, W_DONE
  } walk_st_t;

  typedef struct packed {
    logic              is_ip;
    logic              is_v4;
    logic              is_v6;
    logic              tunnel;
    logic              rt0;
    logic              ver_err;
    logic              csum_err;
    logic              frag;
    logic              short_hdr;
    logic [7:0]        proto;
    logic [15:0]       paylen;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } ip_stat_t;

endpackage

// File: rtl/rx_ip_csum.sv
module rx_ip_csum #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [SUM_W-1:0] sum_nx
);

  localparam int HALF = SUM_W / 2;

  logic [HALF-1:0]  hi_q;
  logic             ph_q;
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_c;
  logic             ph_c;
  logic [SUM_W:0]   wide;

  always_comb begin
    acc_c  = first ? '0 : acc_q;
    ph_c   = first ? 1'b0 : ph_q;
    wide   = {1'b0, acc_c} + {1'b0, hi_q, data[HALF-1:0]};
    sum_nx = wide[SUM_W-1:0] + SUM_W'(wide[SUM_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      ph_q  <= 1'b0;
      acc_q <= '0;
    end else if (en) begin
      if (!ph_c) begin
        hi_q  <= data[HALF-1:0];
        ph_q  <= 1'b1;
        acc_q <= acc_c;
      end else begin
        acc_q <= sum_nx;
        ph_q  <= 1'b0;
      end
    end
  end

  // R4
  cs_phase_chk: assert property (@(posedge clk) disable iff (rst)
    en && first |=> ph_q);

endmodule

// File: rtl/rx_ip_walk.sv
module rx_ip_walk
  import rx_ip_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ETH_LEN = 14,
  parameter int V6_LEN  = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_data,
  input  logic [15:0] cs_sum,
  output logic        cs_en,
  output logic        cs_first,
  output ip_stat_t    stat_nx,
  output logic        fire
);

  localparam int ETY_HI = ETH_LEN - 2;
  localparam int ETY_LO = ETH_LEN - 1;
  localparam int RT_ADDR_BYTES = 16;

  walk_st_t         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [15:0]      hlen_q, hlen_d;
  logic [15:0]      tot_q, tot_d;
  logic [7:0]       ethhi_q, ethhi_d;
  logic [7:0]       rtnh_q, rtnh_d;
  logic [7:0]       rttype_q, rttype_d;
  ip_stat_t         stat_q, stat_d;
  int               idx;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    hlen_d   = hlen_q;
    tot_d    = tot_q;
    ethhi_d  = ethhi_q;
    rtnh_d   = rtnh_q;
    rttype_d = rttype_q;
    stat_d   = stat_q;
    cs_en    = 1'b0;
    cs_first = 1'b0;
    idx      = 0;
    if (in_valid) begin
      if (in_sop) begin
        state_d = W_ETH;
        cnt_d   = '0;
        stat_d  = '0;
      end
      idx = int'(cnt_d);
      case (state_d)
        W_ETH: begin
          cnt_d = cnt_d + CNT_W'(1);
          if (idx == ETY_HI) ethhi_d = in_data;
          if (idx == ETY_LO) begin
            if ({ethhi_d, in_data} == ETY_IPV4 || {ethhi_d, in_data} == ETY_IPV6) begin
              stat_d.is_ip = 1'b1;
              state_d      = W_IP0;
            end else begin
              state_d = W_DONE;
            end
          end
        end
        W_IP0: begin
          cs_en      = 1'b1;
          cs_first   = 1'b1;
          stat_d.src = '0;
          stat_d.dst = '0;
          cnt_d      = CNT_W'(1);
          if (in_data[7:4] == 4'd4) begin
            stat_d.is_v4 = 1'b1;
            stat_d.is_v6 = 1'b0;
            hlen_d       = {10'd0, in_data[3:0], 2'b00};
            if (in_data[3:0] < 4'd5) begin
              stat_d.csum_err = 1'b1;
              state_d         = W_DONE;
            end else begin
              state_d = W_V4;
            end
          end else if (in_data[7:4] == 4'd6) begin
            stat_d.is_v4 = 1'b0;
            stat_d.is_v6 = 1'b1;
            state_d      = W_V6;
          end else begin
            stat_d.is_v4   = 1'b0;
            stat_d.is_v6   = 1'b0;
            stat_d.ver_err = 1'b1;
            state_d        = W_DONE;
          end
        end
        W_V4: begin
          cs_en = 1'b1;
          cnt_d = cnt_d + CNT_W'(1);
          case (idx)
            2: tot_d[15:8] = in_data;
            3: tot_d[7:0]  = in_data;
            6: if (in_data[5] || in_data[4:0] != 5'd0) stat_d.frag = 1'b1;
            7: if (in_data != 8'd0) stat_d.frag = 1'b1;
            9: stat_d.proto = in_data;
            default: ;
          endcase
          if (idx >= 12 && idx < 16) stat_d.src = {stat_d.src[ADDR_W-9:0], in_data};
          if (idx >= 16 && idx < 20) stat_d.dst = {stat_d.dst[ADDR_W-9:0], in_data};
          if (idx == int'(hlen_d) - 1) begin
            if (cs_sum != 16'hFFFF) stat_d.csum_err = 1'b1;
            stat_d.paylen = tot_d - hlen_d;
            if (stat_d.proto == PROTO_6IN4) begin
              stat_d.tunnel = 1'b1;
              state_d       = W_IP0;
            end else begin
              state_d = W_DONE;
            end
          end
        end
        W_V6: begin
          cnt_d = cnt_d + CNT_W'(1);
          case (idx)
            4: stat_d.paylen[15:8] = in_data;
            5: stat_d.paylen[7:0]  = in_data;
            6: stat_d.proto        = in_data;
            default: ;
          endcase
          if (idx >= 8 && idx < 24)      stat_d.src = {stat_d.src[ADDR_W-9:0], in_data};
          if (idx >= 24 && idx < V6_LEN) stat_d.dst = {stat_d.dst[ADDR_W-9:0], in_data};
          if (idx == V6_LEN - 1) begin
            if (stat_d.proto == NH_ROUTING) begin
              state_d = W_RT;
              cnt_d   = '0;
            end else begin
              state_d = W_DONE;
            end
          end
        end
        W_RT: begin
          cnt_d = cnt_d + CNT_W'(1);
          case (idx)
            0: rtnh_d   = in_data;
            1: hlen_d   = ({8'd0, in_data} + 16'd1) << 3;
            2: rttype_d = in_data;
            default: ;
          endcase
          if (idx >= 8 && rttype_d == 8'd0 && hlen_d >= 16'd24 &&
              idx >= int'(hlen_d) - RT_ADDR_BYTES)
            stat_d.dst = {stat_d.dst[ADDR_W-9:0], in_data};
          if (idx >= 2 && idx == int'(hlen_d) - 1) begin
            if (rttype_d == 8'd0) begin
              stat_d.rt0    = 1'b1;
              stat_d.proto  = rtnh_d;
              stat_d.paylen = stat_d.paylen - hlen_d;
            end
            state_d = W_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_nx           = stat_d;
    stat_nx.short_hdr = stat_d.is_ip && (state_d != W_DONE);
    fire              = in_valid && in_eop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= W_DONE;
      cnt_q    <= '0;
      hlen_q   <= '0;
      tot_q    <= '0;
      ethhi_q  <= '0;
      rtnh_q   <= '0;
      rttype_q <= '0;
      stat_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      hlen_q   <= hlen_d;
      tot_q    <= tot_d;
      ethhi_q  <= ethhi_d;
      rtnh_q   <= rtnh_d;
      rttype_q <= rttype_d;
      stat_q   <= stat_d;
    end
  end

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == W_DONE && !(in_valid && in_sop) |=> state_q == W_DONE);

endmodule

// File: rtl/rx_ip_hdr_parser.sv
module rx_ip_hdr_parser
  import rx_ip_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ETH_LEN = 14,
  parameter int V6_LEN  = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [7:0]         in_data,
  output logic               st_valid,
  output logic               st_is_ip,
  output logic               st_is_v4,
  output logic               st_is_v6,
  output logic               st_tunnel,
  output logic               st_rt0,
  output logic               st_ver_err,
  output logic               st_csum_err,
  output logic               st_frag,
  output logic               st_short,
  output logic [7:0]         st_proto,
  output logic [15:0]        st_paylen,
  output logic [ADDR_W-1:0]  st_src,
  output logic [ADDR_W-1:0]  st_dst
);

  logic        cs_en, cs_first, fire;
  logic [15:0] cs_sum;
  ip_stat_t    stat_nx, stat_q;
  logic        valid_q;

  rx_ip_csum #(.SUM_W(16)) u_csum (
    .clk    (clk),
    .rst    (rst),
    .en     (cs_en),
    .first  (cs_first),
    .data   (in_data),
    .sum_nx (cs_sum)
  );

  rx_ip_walk #(.CNT_W(CNT_W), .ETH_LEN(ETH_LEN), .V6_LEN(V6_LEN)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_data  (in_data),
    .cs_sum   (cs_sum),
    .cs_en    (cs_en),
    .cs_first (cs_first),
    .stat_nx  (stat_nx),
    .fire     (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      valid_q <= fire;
      if (fire) stat_q <= stat_nx;
    end
  end

  assign st_valid    = valid_q;
  assign st_is_ip    = stat_q.is_ip;
  assign st_is_v4    = stat_q.is_v4;
  assign st_is_v6    = stat_q.is_v6;
  assign st_tunnel   = stat_q.tunnel;
  assign st_rt0      = stat_q.rt0;
  assign st_ver_err  = stat_q.ver_err;
  assign st_csum_err = stat_q.csum_err;
  assign st_frag     = stat_q.frag;
  assign st_short    = stat_q.short_hdr;
  assign st_proto    = stat_q.proto;
  assign st_paylen   = stat_q.paylen;
  assign st_src      = stat_q.src;
  assign st_dst      = stat_q.dst;

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(in_valid && in_eop));

  // R3
  ver_clear_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ver_err |-> !st_is_v4 && !st_is_v6);

  // R7
  v6_nocsum_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_is_v6 && !st_tunnel |-> !st_csum_err);

  // R2
  nonip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_is_ip |-> !st_is_v4 && !st_is_v6 && !st_ver_err && !st_csum_err && !st_short);

endmodule

// File: tb/test_rx_ip_hdr_parser.sv
`timescale 1ns/100ps
module test_rx_ip_hdr_parser;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]   in_data = 8'd0;
  logic         st_valid, st_is_ip, st_is_v4, st_is_v6, st_tunnel, st_rt0;
  logic         st_ver_err, st_csum_err, st_frag, st_short;
  logic [7:0]   st_proto;
  logic [15:0]  st_paylen;
  logic [127:0] st_src, st_dst;

  int tests = 0;
  int fails = 0;
  logic [7:0] pk [0:255];
  int plen = 0;

  always #2.5 clk = ~clk;

  rx_ip_hdr_parser i_rx_ip_hdr_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .st_valid(st_valid), .st_is_ip(st_is_ip), .st_is_v4(st_is_v4),
    .st_is_v6(st_is_v6), .st_tunnel(st_tunnel), .st_rt0(st_rt0), .st_ver_err(st_ver_err),
    .st_csum_err(st_csum_err), .st_frag(st_frag), .st_short(st_short), .st_proto(st_proto),
    .st_paylen(st_paylen), .st_src(st_src), .st_dst(st_dst)
  );

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    pk[plen] = b;
    plen++;
  endtask

  task automatic eth(logic [15:0] ety);
    plen = 0;
    for (int i = 0; i < 12; i++) put(8'hA0 + 8'(i));
    put(ety[15:8]);
    put(ety[7:0]);
  endtask

  task automatic pay(int n);
    for (int i = 0; i < n; i++) put(8'h5A ^ 8'(i));
  endtask

  function automatic logic [15:0] hdr_cs(int start, int n);
    int unsigned s = 0;
    for (int i = 0; i < n; i += 2) s += {pk[start+i], pk[start+i+1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic v4hdr(logic [3:0] ihl, logic [15:0] tot, logic [7:0] b6, logic [7:0] b7,
                       logic [7:0] proto, logic [31:0] s, logic [31:0] d, bit bad);
    int st;
    logic [15:0] cs;
    st = plen;
    put({4'h4, ihl}); put(8'h00); put(tot[15:8]); put(tot[7:0]);
    put(8'h12); put(8'h34); put(b6); put(b7); put(8'd64); put(proto);
    put(8'h00); put(8'h00);
    for (int i = 3; i >= 0; i--) put(s[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) put(d[i*8 +: 8]);
    for (int i = 5; i < int'(ihl); i++) begin put(8'h01); put(8'h01); put(8'h01); put(8'h00); end
    if (ihl >= 4'd5) begin
      cs = hdr_cs(st, int'(ihl) * 4);
      if (bad) cs = cs ^ 16'h0001;
      pk[st+10] = cs[15:8];
      pk[st+11] = cs[7:0];
    end
  endtask

  task automatic v6hdr(logic [15:0] pl, logic [7:0] nh, logic [127:0] s, logic [127:0] d);
    put(8'h60); put(8'h00); put(8'h00); put(8'h00);
    put(pl[15:8]); put(pl[7:0]); put(nh); put(8'd64);
    for (int i = 15; i >= 0; i--) put(s[i*8 +: 8]);
    for (int i = 15; i >= 0; i--) put(d[i*8 +: 8]);
  endtask

  task automatic rthdr(logic [7:0] nh, logic [7:0] len8, logic [7:0] typ, logic [127:0] last);
    put(nh); put(len8); put(typ); put(8'd1);
    put(8'h00); put(8'h00); put(8'h00); put(8'h00);
    for (int a = 0; a < int'(len8) / 2; a++)
      for (int i = 15; i >= 0; i--)
        put((a == int'(len8) / 2 - 1) ? last[i*8 +: 8] : 8'hEE);
  endtask

  task automatic send(bit gap, bit noeop);
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == plen - 1) && !noeop;
      in_data  = pk[i];
      if (gap && (i % 5 == 3)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic expect_st(string tag, bit ip, bit v4, bit v6, bit tun, bit rt0, bit ver,
                           bit cs, bit fr, bit sh, logic [7:0] pr, logic [15:0] pl,
                           logic [127:0] s, logic [127:0] d);
    chk(tag, "valid", st_valid, 1);
    chk(tag, "is_ip", st_is_ip, ip);
    chk(tag, "is_v4", st_is_v4, v4);
    chk(tag, "is_v6", st_is_v6, v6);
    chk(tag, "tunnel", st_tunnel, tun);
    chk(tag, "rt0", st_rt0, rt0);
    chk(tag, "ver_err", st_ver_err, ver);
    chk(tag, "csum_err", st_csum_err, cs);
    chk(tag, "frag", st_frag, fr);
    chk(tag, "short", st_short, sh);
    chk(tag, "proto", st_proto, pr);
    chk(tag, "paylen", st_paylen, pl);
    chk(tag, "src", st_src, s);
    chk(tag, "dst", st_dst, d);
    @(negedge clk);
    chk("R1", "valid one cycle", st_valid, 0);
  endtask

  localparam logic [31:0]  A4 = 32'hC0A80001, B4 = 32'hC0A80002;
  localparam logic [127:0] A6 = 128'h20010DB8_00000000_00000000_00000001;
  localparam logic [127:0] B6 = 128'h20010DB8_00000000_00000000_000000B2;
  localparam logic [127:0] C6 = 128'hFE800000_00000000_00000000_0000C0DE;

  task automatic t_reset();
    chk("R1", "reset valid", st_valid, 0);
    chk("R1", "reset is_ip", st_is_ip, 0);
    chk("R1", "reset proto", st_proto, 0);
    chk("R1", "reset src", st_src, 0);
  endtask

  task automatic t_v4_basic();
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h00, 8'h00, 8'd17, A4, B4, 0); pay(8);
    send(0, 0);
    expect_st("R5", 1,1,0,0,0,0,0,0,0, 8'd17, 16'd8, {96'd0, A4}, {96'd0, B4});
  endtask

  task automatic t_v4_badcs();
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h00, 8'h00, 8'd6, A4, B4, 1); pay(8);
    send(0, 0);
    expect_st("R4", 1,1,0,0,0,0,1,0,0, 8'd6, 16'd8, {96'd0, A4}, {96'd0, B4});
  endtask

  task automatic t_v4_frag();
    eth(16'h0800); v4hdr(4'd6, 16'd44, 8'h20, 8'h00, 8'd17, A4, B4, 0); pay(20);
    send(0, 0);
    expect_st("R6", 1,1,0,0,0,0,0,1,0, 8'd17, 16'd20, {96'd0, A4}, {96'd0, B4});
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h00, 8'h10, 8'd17, A4, B4, 0); pay(8);
    send(0, 0);
    expect_st("R6", 1,1,0,0,0,0,0,1,0, 8'd17, 16'd8, {96'd0, A4}, {96'd0, B4});
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h40, 8'h00, 8'd17, A4, B4, 0); pay(8);
    send(0, 0);
    expect_st("R6", 1,1,0,0,0,0,0,0,0, 8'd17, 16'd8, {96'd0, A4}, {96'd0, B4});
  endtask

  task automatic t_v4_ihl4();
    eth(16'h0800); v4hdr(4'd4, 16'd28, 8'h00, 8'h00, 8'd17, A4, B4, 0); pay(8);
    send(0, 0);
    expect_st("R4", 1,1,0,0,0,0,1,0,0, 8'd0, 16'd0, 128'd0, 128'd0);
  endtask

  task automatic t_nonip();
    eth(16'h0806); pay(28);
    send(0, 0);
    expect_st("R2", 0,0,0,0,0,0,0,0,0, 8'd0, 16'd0, 128'd0, 128'd0);
  endtask

  task automatic t_ver5();
    eth(16'h0800); put(8'h55); pay(27);
    send(0, 0);
    expect_st("R3", 1,0,0,0,0,1,0,0,0, 8'd0, 16'd0, 128'd0, 128'd0);
  endtask

  task automatic t_v6();
    eth(16'h86DD); v6hdr(16'd16, 8'd6, A6, B6); pay(16);
    send(0, 0);
    expect_st("R7", 1,0,1,0,0,0,0,0,0, 8'd6, 16'd16, A6, B6);
  endtask

  task automatic t_rt0();
    eth(16'h86DD); v6hdr(16'd40, 8'd43, A6, B6); rthdr(8'd6, 8'd2, 8'd0, C6); pay(16);
    send(0, 0);
    expect_st("R9", 1,0,1,0,1,0,0,0,0, 8'd6, 16'd16, A6, C6);
  endtask

  task automatic t_rt2();
    eth(16'h86DD); v6hdr(16'd40, 8'd43, A6, B6); rthdr(8'd17, 8'd2, 8'd2, C6); pay(16);
    send(0, 0);
    expect_st("R9", 1,0,1,0,0,0,0,0,0, 8'd43, 16'd40, A6, B6);
  endtask

  task automatic t_tunnel();
    eth(16'h0800); v4hdr(4'd5, 16'd68, 8'h00, 8'h00, 8'd41, A4, B4, 0);
    v6hdr(16'd8, 8'd17, A6, B6); pay(8);
    send(0, 0);
    expect_st("R8", 1,0,1,1,0,0,0,0,0, 8'd17, 16'd8, A6, B6);
  endtask

  task automatic t_short();
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h00, 8'h00, 8'd17, A4, B4, 0);
    plen = 24;
    send(0, 0);
    expect_st("R10", 1,1,0,0,0,0,0,0,1, 8'd17, 16'd0, 128'd0, 128'd0);
  endtask

  task automatic t_restart();
    eth(16'h0800); v4hdr(4'd5, 16'd28, 8'h00, 8'h00, 8'd17, A4, B4, 1);
    plen = 30;
    send(0, 1);
    chk("R11", "no status without eop", st_valid, 0);
    eth(16'h86DD); v6hdr(16'd12, 8'd17, B6, A6); pay(12);
    send(1, 0);
    expect_st("R11", 1,0,1,0,0,0,0,0,0, 8'd17, 16'd12, B6, A6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_v4_basic();
    t_v4_badcs();
    t_v4_frag();
    t_v4_ihl4();
    t_nonip();
    t_ver5();
    t_v6();
    t_rt0();
    t_rt2();
    t_tunnel();
    t_short();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule